// File: doc/BRIEF.md
# Received Packet Word Sequencer

This block takes a received serial-bus packet, already addressed and routed inside the chip, and sends it out on an external 16-bit word port that runs on the port clock. It first takes a packet descriptor, which gives the number of header quadlets and the number of payload quadlets. It then pulls 32-bit quadlets from a quadlet source in this order: headers, payload, one trailer. Each quadlet leaves the block as two 16-bit words, the upper half first. Three control lines frame the words: a transfer strobe, a packet flag and a one-cycle done pulse.

A static format input selects one of two framings. In full framing, the done pulse comes first. The strobe then covers every header, payload and trailer word, and the flag marks the header and trailer words. In payload-only framing, the header quadlets are read and discarded without reaching the port, and the done pulse follows the last of them. The strobe covers only the payload words. The two trailer words are placed on the port after the strobe has fallen.

Both inputs use valid/ready. A transfer happens on a clock edge where both valid and ready are high. Neither ready depends on its own valid. A source that raises valid must hold its data until the transfer. When the quadlet source withholds a quadlet the block needs, the block holds its state and outputs.

Top module: `rx_mover_seq`

## Requirements
- R1: Synchronous active-high reset leaves the block idle, with strobe, flag and done low, the word bus at zero and pkt_ready high.
- R2: In full framing (fmt_full=1), every quadlet is shown as two words on consecutive cycles, bits 31:16 first and then bits 15:0, with the strobe high on each of these words.
- R3: In full framing, done is high for exactly the one cycle after the descriptor is accepted, with strobe low and the bus at zero; the first header word follows in the next cycle.
- R4: In full framing, the flag is high on header words and on trailer words, and low on payload words.
- R5: After the second trailer word, the block spends one cycle with all outputs low and then raises pkt_ready again.
- R6: In payload-only framing (fmt_full=0), the block takes one header quadlet per cycle with all outputs low and nothing on the bus; done pulses in the cycle after the last header is taken, or right after acceptance when the header count is zero.
- R7: In payload-only framing, the flag never rises and the strobe is high exactly while payload words are on the bus.
- R8: In payload-only framing, the two trailer words follow the last payload word immediately, with the strobe low.
- R9: While the quadlet source withholds a quadlet the block is waiting for, all outputs hold. Once the quadlet arrives, the sequence resumes with no word skipped.
- R10: If the first quadlet is late, done still lasts one cycle, and the strobe stays low until that quadlet arrives.
- R11: A packet with zero header quadlets and a single payload quadlet is framed correctly in both formats.
- R12: pkt_ready is low from the cycle after acceptance until the packet is finished, so a new descriptor is not taken mid-packet.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Port clock |
| rst | input | 1 | Synchronous reset, active high |
| fmt_full | input | 1 | Static format select: 1 full framing, 0 payload-only framing |
| pkt_valid | input | 1 | Descriptor valid |
| pkt_ready | output | 1 | Descriptor ready (block idle) |
| pkt_hdr_cnt | input | HCW (3) | Header quadlet count of the packet |
| pkt_pay_cnt | input | PCW (4) | Payload quadlet count of the packet |
| q_valid | input | 1 | Quadlet source valid |
| q_ready | output | 1 | Quadlet source ready |
| q_data | input | 2*DW (32) | Quadlet from the source |
| dm_data | output | DW (16) | Word bus to the port |
| dm_strobe | output | 1 | Transfer strobe |
| dm_flag | output | 1 | Header/trailer flag |
| dm_done | output | 1 | One-cycle packet start pulse |

## Verification
The bench uses the default parameters: a 16-bit word, headers counted up to 7 and payloads up to 15 quadlets. With these values the bench reaches packets with no header, packets with a single payload quadlet, and packets at the full count limits. Random stalls of the quadlet source are placed on every quadlet except the one fetched during the done cycle. A directed late-first-quadlet case covers that one.

// File: rtl/rxm_pkg.sv
package rxm_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_SKIP,
    S_DONE,
    S_FETCH,
    S_HDR,
    S_PAY,
    S_TRL,
    S_END
  } rxm_state_e;
endpackage

// File: rtl/rxm_downcnt.sv
module rxm_downcnt #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic         zero,
  output logic         one
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (load) cnt <= load_val;
    else if (dec)  cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
  assign one  = (cnt == W'(1));

  // R9
  no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
    (dec && !load) |-> (cnt != '0));
endmodule

// File: rtl/rxm_qbuf.sv
module rxm_qbuf #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          step,
  input  logic [2*DW-1:0] qin,
  output logic          half,
  output logic [DW-1:0] word
);
  logic [2*DW-1:0] buf_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      buf_q <= '0;
      half  <= 1'b0;
    end else if (load) begin
      buf_q <= qin;
      half  <= 1'b0;
    end else if (step) begin
      half  <= 1'b1;
    end
  end

  assign word = half ? buf_q[DW-1:0] : buf_q[2*DW-1:DW];

  // R2
  upper_first_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> !half);
endmodule

// File: rtl/rxm_fsm.sv
module rxm_fsm
  import rxm_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic fmt_full,
  input  logic pkt_valid,
  input  logic acc_hdr_zero,
  input  logic q_valid,
  input  logic hdr_zero,
  input  logic hdr_one,
  input  logic pay_zero,
  input  logic half,
  output logic pkt_ready,
  output logic q_ready,
  output logic accept,
  output logic load,
  output logic step,
  output logic dec_hdr,
  output logic dec_pay,
  output logic bus_en,
  output logic dm_strobe,
  output logic dm_flag,
  output logic dm_done
);
  rxm_state_e st, nxt;
  logic       full_q;
  logic       fetch;
  logic       emit_mid;
  rxm_state_e kind_st;

  // the kind of the next quadlet to fetch follows from the remaining counts
  always_comb begin
    if (!hdr_zero)      kind_st = S_HDR;
    else if (!pay_zero) kind_st = S_PAY;
    else                kind_st = S_TRL;
  end

  assign emit_mid  = (st == S_HDR || st == S_PAY) && half;
  assign pkt_ready = (st == S_IDLE);
  assign q_ready   = (st == S_SKIP) || (st == S_DONE) || (st == S_FETCH) || emit_mid;
  assign fetch     = q_ready && q_valid;
  assign accept    = pkt_ready && pkt_valid;
  assign load      = fetch && (st != S_SKIP);
  assign step      = (st == S_HDR || st == S_PAY || st == S_TRL) && !half;
  assign dec_hdr   = fetch && !hdr_zero;
  assign dec_pay   = fetch && hdr_zero && !pay_zero;

  always_comb begin
    nxt = st;
    unique case (st)
      S_IDLE:  if (pkt_valid) nxt = (!fmt_full && !acc_hdr_zero) ? S_SKIP : S_DONE;
      S_SKIP:  if (q_valid && hdr_one) nxt = S_DONE;
      S_DONE:  nxt = q_valid ? kind_st : S_FETCH;
      S_FETCH: if (q_valid) nxt = kind_st;
      S_HDR,
      S_PAY:   if (half && q_valid) nxt = kind_st;
      S_TRL:   if (half) nxt = S_END;
      S_END:   nxt = S_IDLE;
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= S_IDLE;
      full_q <= 1'b0;
    end else begin
      st <= nxt;
      if (accept) full_q <= fmt_full;
    end
  end

  assign bus_en    = (st == S_HDR) || (st == S_PAY) || (st == S_TRL);
  assign dm_done   = (st == S_DONE);
  assign dm_strobe = (st == S_HDR) || (st == S_PAY) || (st == S_TRL && full_q);
  assign dm_flag   = full_q && (st == S_HDR || st == S_TRL);

  // R3
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    dm_done |=> !dm_done);
  // R4
  flag_in_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    dm_flag |-> dm_strobe);
  // R7
  no_flag_short_chk: assert property (@(posedge clk) disable iff (rst)
    (!full_q && !pkt_ready) |-> !dm_flag);
  // R12
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (rst)
    accept |=> !pkt_ready);
  // R10
  done_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    dm_done |-> (!dm_strobe && !dm_flag));
endmodule

// File: rtl/rx_mover_seq.sv
module rx_mover_seq #(
  parameter int DW  = 16,
  parameter int HCW = 3,
  parameter int PCW = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            fmt_full,
  input  logic            pkt_valid,
  output logic            pkt_ready,
  input  logic [HCW-1:0]  pkt_hdr_cnt,
  input  logic [PCW-1:0]  pkt_pay_cnt,
  input  logic            q_valid,
  output logic            q_ready,
  input  logic [2*DW-1:0] q_data,
  output logic [DW-1:0]   dm_data,
  output logic            dm_strobe,
  output logic            dm_flag,
  output logic            dm_done
);
  localparam int QW = 2 * DW;

  logic accept, load, step, dec_hdr, dec_pay, bus_en;
  logic hdr_zero, hdr_one, pay_zero, pay_one, half;
  logic [DW-1:0] word;
  logic [QW-1:0] qin;

  assign qin = q_data;

  rxm_downcnt #(.W(HCW)) u_hcnt (
    .clk(clk), .rst(rst), .load(accept), .load_val(pkt_hdr_cnt),
    .dec(dec_hdr), .zero(hdr_zero), .one(hdr_one)
  );

  rxm_downcnt #(.W(PCW)) u_pcnt (
    .clk(clk), .rst(rst), .load(accept), .load_val(pkt_pay_cnt),
    .dec(dec_pay), .zero(pay_zero), .one(pay_one)
  );

  rxm_qbuf #(.DW(DW)) u_qbuf (
    .clk(clk), .rst(rst), .load(load), .step(step),
    .qin(qin), .half(half), .word(word)
  );

  rxm_fsm u_fsm (
    .clk(clk), .rst(rst), .fmt_full(fmt_full), .pkt_valid(pkt_valid),
    .acc_hdr_zero(pkt_hdr_cnt == '0), .q_valid(q_valid),
    .hdr_zero(hdr_zero), .hdr_one(hdr_one), .pay_zero(pay_zero), .half(half),
    .pkt_ready(pkt_ready), .q_ready(q_ready), .accept(accept), .load(load),
    .step(step), .dec_hdr(dec_hdr), .dec_pay(dec_pay), .bus_en(bus_en),
    .dm_strobe(dm_strobe), .dm_flag(dm_flag), .dm_done(dm_done)
  );

  assign dm_data = bus_en ? word : '0;

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (q_ready && !q_valid && dm_strobe) |=> ($stable(dm_data) && dm_strobe));
  // R11
  last_pay_chk: assert property (@(posedge clk) disable iff (rst)
    (dec_pay && pay_one) |=> (pay_zero && !dm_flag));
endmodule

// File: tb/rx_mover_seq_tb.sv
module rx_mover_seq_tb;
  localparam int CLK_NS = 10;
  localparam int DW  = 16;
  localparam int HCW = 3;
  localparam int PCW = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic fmt_full = 1'b1;
  logic pkt_valid = 1'b0;
  logic pkt_ready;
  logic [HCW-1:0] pkt_hdr_cnt = '0;
  logic [PCW-1:0] pkt_pay_cnt = '0;
  logic q_valid = 1'b0;
  logic q_ready;
  logic [2*DW-1:0] q_data = '0;
  logic [DW-1:0] dm_data;
  logic dm_strobe, dm_flag, dm_done;

  int total = 0;
  int bad = 0;

  always #(CLK_NS/2) clk = ~clk;

  rx_mover_seq #(.DW(DW), .HCW(HCW), .PCW(PCW)) u_dut (
    .clk(clk), .rst(rst), .fmt_full(fmt_full), .pkt_valid(pkt_valid),
    .pkt_ready(pkt_ready), .pkt_hdr_cnt(pkt_hdr_cnt), .pkt_pay_cnt(pkt_pay_cnt),
    .q_valid(q_valid), .q_ready(q_ready), .q_data(q_data),
    .dm_data(dm_data), .dm_strobe(dm_strobe), .dm_flag(dm_flag), .dm_done(dm_done)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // expected entry: {strobe, flag, done, word}
  function automatic logic [18:0] ent(bit s, bit f, bit d, logic [15:0] w);
    return {s, f, d, w};
  endfunction

  task automatic run_pkt(input bit full, input int h, input int p,
                         input bit stalls, input string xtag);
    logic [31:0] qa[$];
    int stl[$];
    logic [18:0] ex[$];
    int n, idx, scnt, e, guard, mism;
    bit hs_prev, st_now, any_stall;
    int bs, bf, bd, bw;
    int as_, es, af, ef, ad, ed, aw, ew;
    n = h + p + 1;
    for (int i = 0; i < n; i++) begin
      qa.push_back($urandom);
      stl.push_back((stalls && ($urandom % 3 == 0)) ? int'($urandom % 3) + 1 : 0);
    end
    stl[full ? 0 : h] = 0;
    // expected trace
    if (full) begin
      ex.push_back(ent(0, 0, 1, 16'h0));
      for (int i = 0; i < n; i++) begin
        bit fl = (i < h) || (i == n - 1);
        ex.push_back(ent(1, fl, 0, qa[i][31:16]));
        ex.push_back(ent(1, fl, 0, qa[i][15:0]));
      end
    end else begin
      for (int i = 0; i < h; i++) ex.push_back(ent(0, 0, 0, 16'h0));
      ex.push_back(ent(0, 0, 1, 16'h0));
      for (int i = h; i < n; i++) begin
        bit sb = (i != n - 1);
        ex.push_back(ent(sb, 0, 0, qa[i][31:16]));
        ex.push_back(ent(sb, 0, 0, qa[i][15:0]));
      end
    end
    ex.push_back(ent(0, 0, 0, 16'h0));

    @(negedge clk);
    guard = 0;
    while (!pkt_ready && guard < 100) begin @(negedge clk); guard++; end
    fmt_full = full; pkt_valid = 1'b1;
    pkt_hdr_cnt = HCW'(h); pkt_pay_cnt = PCW'(p);
    idx = 0; scnt = stl[0];
    q_valid = (scnt == 0); q_data = qa[0];
    hs_prev = q_valid && q_ready;
    @(negedge clk);
    pkt_valid = 1'b0;
    chk(!pkt_ready, "R12", "pkt_ready while busy", pkt_ready, 0);
    e = 0; guard = 0; mism = 0; any_stall = 0;
    bs = 0; bf = 0; bd = 0; bw = 0;
    as_ = 0; es = 0; af = 0; ef = 0; ad = 0; ed = 0; aw = 0; ew = 0;
    while (e < ex.size() && guard < 2000) begin
      guard++;
      if (dm_strobe !== ex[e][18]) begin if (bs == 0) begin as_ = dm_strobe; es = ex[e][18]; end bs++; end
      if (dm_flag   !== ex[e][17]) begin if (bf == 0) begin af = dm_flag;   ef = ex[e][17]; end bf++; end
      if (dm_done   !== ex[e][16]) begin if (bd == 0) begin ad = dm_done;   ed = ex[e][16]; end bd++; end
      if (dm_data   !== ex[e][15:0]) begin if (bw == 0) begin aw = dm_data; ew = ex[e][15:0]; end bw++; end
      if (hs_prev) begin
        idx++;
        scnt = (idx < n) ? stl[idx] : 0;
      end else if (scnt > 0) scnt--;
      q_valid = (idx < n) && (scnt == 0);
      q_data  = (idx < n) ? qa[idx] : '0;
      hs_prev = q_valid && q_ready;
      st_now  = q_ready && !q_valid;
      if (st_now) any_stall = 1;
      @(negedge clk);
      if (!st_now) e++;
    end
    q_valid = 1'b0;
    mism = bs + bf + bd + bw;
    chk(bs == 0, full ? "R2" : "R7", "strobe", as_, es);
    chk(bf == 0, full ? "R4" : "R7", "flag", af, ef);
    chk(bd == 0, full ? "R3" : "R6", "done", ad, ed);
    chk(bw == 0, full ? "R2" : "R8", "word", aw, ew);
    chk(pkt_ready && !dm_strobe, "R5", "idle after packet", pkt_ready, 1);
    if (any_stall) chk(mism == 0, "R9", "stalled packet mismatches", mism, 0);
    if (xtag != "") chk(mism == 0, xtag, "directed packet mismatches", mism, 0);
  endtask

  task automatic late_first();
    logic [31:0] qa[3];
    int idx, guard;
    bit hs_prev;
    for (int i = 0; i < 3; i++) qa[i] = $urandom;
    @(negedge clk);
    guard = 0;
    while (!pkt_ready && guard < 100) begin @(negedge clk); guard++; end
    fmt_full = 1'b1; pkt_valid = 1'b1; pkt_hdr_cnt = HCW'(1); pkt_pay_cnt = PCW'(1);
    q_valid = 1'b0;
    @(negedge clk);
    pkt_valid = 1'b0;
    chk(dm_done == 1'b1, "R10", "done at start", dm_done, 1);
    @(negedge clk);
    chk(!dm_done && !dm_strobe, "R10", "done/strobe while waiting",
        {dm_done, dm_strobe}, 0);
    @(negedge clk);
    chk(!dm_done && !dm_strobe, "R10", "still waiting", {dm_done, dm_strobe}, 0);
    q_valid = 1'b1; q_data = qa[0];
    hs_prev = q_ready;
    @(negedge clk);
    chk(dm_strobe && dm_flag && dm_data == qa[0][31:16], "R10", "first word after late quadlet",
        dm_data, qa[0][31:16]);
    idx = 0; guard = 0;
    while (!pkt_ready && guard < 100) begin
      guard++;
      if (hs_prev) idx++;
      q_valid = (idx < 3);
      q_data  = (idx < 3) ? qa[idx] : '0;
      hs_prev = q_valid && q_ready;
      @(negedge clk);
    end
    q_valid = 1'b0;
    chk(pkt_ready, "R5", "idle after late packet", pkt_ready, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1394));
    repeat (3) @(negedge clk);
    // R1
    chk(!dm_strobe && !dm_flag && !dm_done && dm_data == '0 && pkt_ready,
        "R1", "reset state", {dm_strobe, dm_flag, dm_done}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!dm_strobe && dm_data == '0 && pkt_ready, "R1", "after release", dm_data, 0);

    run_pkt(1, 0, 1, 0, "R11");
    run_pkt(0, 0, 1, 0, "R11");
    run_pkt(1, 4, 3, 0, "");
    run_pkt(0, 3, 3, 0, "");
    run_pkt(1, 7, 15, 0, "");
    run_pkt(0, 7, 15, 0, "");
    late_first();
    for (int k = 0; k < 40; k++) begin
      run_pkt(($urandom % 2) == 1, int'($urandom % 5), int'($urandom % 8) + 1,
              k >= 10, "");
    end
    run_pkt(1, 2, 4, 1, "");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule